// File: doc/BRIEF.md
# Interlocked Four-Phase Read Handshake Pair

This block holds both ends of a one-word read carried over a shared bidirectional bus. The bus has no common clock. A requester controller takes a read command and places the address on the shared lines. A responder controller captures that address, runs a memory access of fixed latency, and returns the word on the same lines. Three handshake lines carry the exchange: a request line, a data-ready line and an acknowledge line. Both ends raise and lower the acknowledge line, and it is the wired OR of their two drivers. Each controller is a synchronous FSM. Every handshake line passes through a two-flop synchronizer before an FSM reads it, so the two ends could sit in separate clock domains.

The exchange runs as two interlocked phases. In the address phase, the request rises and the acknowledge rises; then the request falls and the acknowledge falls. In the data phase, data-ready rises and the acknowledge rises; then data-ready falls and the acknowledge falls. The memory access starts when the address is captured. It runs while the address-phase release steps complete, so the release time is hidden behind the memory latency. The shared bus appears at the ports as one drive-enable per end and the resolved bus value, so bus ownership can be observed directly.

The command input is a valid/ready stream. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the requester ignores `cmd_valid` and `cmd_addr`. The result is a one-cycle `done` strobe with `done_data` valid in that cycle. The result has no back-pressure: the consumer must take the word when it is offered. The memory port is combinational toward the block. `mem_rdata` must reflect `mem_addr`, which stays stable throughout each access.

Top module: `rdhs_top`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, all three handshake lines are low and neither end drives the bus.
- R2: `cmd_ready` is high only when the requester is idle and all three handshake lines are low. A `cmd_valid` presented while `cmd_ready` is low starts no transfer and produces no `done`.
- R3: `bus_req_drv` and `bus_rsp_drv` are never high in the same cycle.
- R4: While `hs_req` is high, the requester drives the command address onto the bus. When the acknowledge rises in the address phase, `hs_req` is high and `mem_addr` equals the address on the bus.
- R5: The requester lowers `hs_req` and stops driving in the same cycle, and does so only while the acknowledge is high. The responder lowers the acknowledge only after the request is low.
- R6: `hs_rdy` rises no earlier than LATENCY cycles after the address-phase acknowledge rises. When LATENCY is at least 9, the gap is exactly LATENCY+1 cycles.
- R7: While `hs_rdy` is high, only the responder drives the bus. In the cycle `hs_rdy` rises, the bus carries the memory word for the captured address.
- R8: The requester raises the acknowledge in response to `hs_rdy`, without driving the bus. `done` lasts exactly one cycle, and `done_data` equals the memory word for the commanded address.
- R9: `hs_rdy` falls only while the acknowledge is high, and the responder releases the bus in the same cycle.
- R10: The acknowledge falls only while `hs_rdy` is low. The final acknowledge fall of a transfer coincides with the `done` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Requester can take a command |
| cmd_addr | input | W | Address of the read |
| done | output | 1 | One-cycle completion strobe |
| done_data | output | W | Word read, valid with `done` |
| mem_addr | output | W | Address captured by the responder |
| mem_rdata | input | W | Memory word for `mem_addr` |
| bus_req_drv | output | 1 | Requester drives the shared bus |
| bus_rsp_drv | output | 1 | Responder drives the shared bus |
| bus_val | output | W | Resolved shared bus value |
| hs_req | output | 1 | Request line |
| hs_ack | output | 1 | Acknowledge line (OR of both ends) |
| hs_rdy | output | 1 | Data-ready line |

## Verification
The assertions rely on two assumptions. First, `mem_rdata` must be a pure function of `mem_addr`, so the word does not change while an access is in flight. Second, a command transfers only on an edge where `cmd_ready` is high. The bench meets both conditions. Its memory model is combinational over `mem_addr`. Its only off-protocol stimulus is a stray `cmd_valid` during a busy transfer, and the bench withdraws that request before `cmd_ready` can rise again. The latency is set above the release time, so the exact data-ready gap of R6 can be measured at the ports.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_AREL,
    RQ_DWAIT,
    RQ_DACK
  } rq_state_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK,
    RS_AREL,
    RS_RDY,
    RS_END
  } rs_state_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = rdhs_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rdhs_lat_timer.sv
module rdhs_lat_timer #(
  parameter int unsigned W       = 32,
  parameter int unsigned LATENCY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] rdata_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned CW = $clog2(LATENCY + 1) + 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (start_i) begin
      cnt_q   <= CW'(LATENCY);
      busy_q  <= 1'b1;
      valid_o <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        data_o  <= rdata_i;
        valid_o <= 1'b1;
        busy_q  <= 1'b0;
      end
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_addr,
  input  logic         ack_s,
  input  logic         rdy_s,
  input  logic [W-1:0] bus_in,
  output logic         req_o,
  output logic         ack_o,
  output logic         drv_o,
  output logic [W-1:0] val_o,
  output logic         done_o,
  output logic [W-1:0] done_data_o
);
  rq_state_e st_q;

  assign cmd_ready = (st_q == RQ_IDLE) && !req_o && !ack_s && !rdy_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= RQ_IDLE;
      req_o       <= 1'b0;
      ack_o       <= 1'b0;
      drv_o       <= 1'b0;
      val_o       <= '0;
      done_o      <= 1'b0;
      done_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        RQ_IDLE: if (cmd_valid && cmd_ready) begin
          val_o <= cmd_addr;
          drv_o <= 1'b1;
          req_o <= 1'b1;
          st_q  <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          req_o <= 1'b0;
          drv_o <= 1'b0;
          st_q  <= RQ_AREL;
        end
        RQ_AREL: if (!ack_s) st_q <= RQ_DWAIT;
        RQ_DWAIT: if (rdy_s) begin
          done_data_o <= bus_in;
          ack_o       <= 1'b1;
          st_q        <= RQ_DACK;
        end
        RQ_DACK: if (!rdy_s) begin
          ack_o  <= 1'b0;
          done_o <= 1'b1;
          st_q   <= RQ_IDLE;
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
  import rdhs_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned LATENCY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_s,
  input  logic         ack_s,
  input  logic [W-1:0] bus_in,
  output logic         ack_o,
  output logic         rdy_o,
  output logic         drv_o,
  output logic [W-1:0] val_o,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata
);
  rs_state_e    st_q;
  logic         start;
  logic         word_ok;
  logic [W-1:0] word;

  assign start = (st_q == RS_IDLE) && req_s;

  rdhs_lat_timer #(.W(W), .LATENCY(LATENCY)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .rdata_i(mem_rdata),
    .valid_o(word_ok),
    .data_o (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RS_IDLE;
      ack_o    <= 1'b0;
      rdy_o    <= 1'b0;
      drv_o    <= 1'b0;
      val_o    <= '0;
      mem_addr <= '0;
    end else begin
      unique case (st_q)
        RS_IDLE: if (req_s) begin
          mem_addr <= bus_in;
          ack_o    <= 1'b1;
          st_q     <= RS_ACK;
        end
        RS_ACK: if (!req_s) begin
          ack_o <= 1'b0;
          st_q  <= RS_AREL;
        end
        RS_AREL: if (!ack_s && word_ok) begin
          val_o <= word;
          drv_o <= 1'b1;
          rdy_o <= 1'b1;
          st_q  <= RS_RDY;
        end
        RS_RDY: if (ack_s) begin
          rdy_o <= 1'b0;
          drv_o <= 1'b0;
          st_q  <= RS_END;
        end
        RS_END: if (!ack_s) st_q <= RS_IDLE;
        default: st_q <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdhs_top.sv
module rdhs_top #(
  parameter int unsigned W       = 32,
  parameter int unsigned LATENCY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_addr,
  output logic         done,
  output logic [W-1:0] done_data,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         bus_req_drv,
  output logic         bus_rsp_drv,
  output logic [W-1:0] bus_val,
  output logic         hs_req,
  output logic         hs_ack,
  output logic         hs_rdy
);
  logic         rq_ack, rs_ack;
  logic [W-1:0] rq_val, rs_val;
  logic [1:0]   rq_in_s, rs_in_s;

  assign hs_ack  = rq_ack | rs_ack;
  assign bus_val = bus_req_drv ? rq_val : (bus_rsp_drv ? rs_val : '0);

  rdhs_sync #(.W(2)) rq_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i({hs_ack, hs_rdy}), .q_o(rq_in_s)
  );

  rdhs_sync #(.W(2)) rs_sync_i (
    .clk(clk), .rst_n(rst_n), .d_i({hs_req, hs_ack}), .q_o(rs_in_s)
  );

  rdhs_requester #(.W(W)) rq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .ack_s      (rq_in_s[1]),
    .rdy_s      (rq_in_s[0]),
    .bus_in     (bus_val),
    .req_o      (hs_req),
    .ack_o      (rq_ack),
    .drv_o      (bus_req_drv),
    .val_o      (rq_val),
    .done_o     (done),
    .done_data_o(done_data)
  );

  rdhs_responder #(.W(W), .LATENCY(LATENCY)) rs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_s    (rs_in_s[1]),
    .ack_s    (rs_in_s[0]),
    .bus_in   (bus_val),
    .ack_o    (rs_ack),
    .rdy_o    (hs_rdy),
    .drv_o    (bus_rsp_drv),
    .val_o    (rs_val),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/rdhs_chk.sv
module rdhs_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned LATENCY = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_ready,
  input logic         done,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_rdata,
  input logic         bus_req_drv,
  input logic         bus_rsp_drv,
  input logic [W-1:0] bus_val,
  input logic         hs_req,
  input logic         hs_ack,
  input logic         hs_rdy
);
  localparam int unsigned GW = $clog2(LATENCY + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic          ack_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      gap_q <= '0;
    end else begin
      ack_q <= hs_ack;
      if (hs_ack && !ack_q && !hs_rdy) gap_q <= '0;
      else if (gap_q != GMAX)          gap_q <= gap_q + GW'(1);
    end
  end

  // R2
  ready_idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!hs_req && !hs_ack && !hs_rdy));

  // R3
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req_drv && bus_rsp_drv));

  // R4
  req_drives_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |-> bus_req_drv);

  // R4
  addr_ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_ack) && !hs_rdy) |-> (hs_req && mem_addr == bus_val));

  // R5
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_req) |-> (hs_ack && !bus_req_drv));

  // R6
  rdy_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_rdy) |-> (gap_q >= GW'(LATENCY)));

  // R7
  rdy_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rdy |-> (bus_rsp_drv && !bus_req_drv));

  // R7
  rdy_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_rdy) |-> (bus_val == mem_rdata));

  // R8
  data_ack_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_ack) && hs_rdy) |-> !bus_req_drv);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_rdy) |-> (hs_ack && !bus_rsp_drv));

  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_ack) |-> !hs_rdy);
endmodule

bind rdhs_top rdhs_chk #(.W(W), .LATENCY(LATENCY)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .done       (done),
  .mem_addr   (mem_addr),
  .mem_rdata  (mem_rdata),
  .bus_req_drv(bus_req_drv),
  .bus_rsp_drv(bus_rsp_drv),
  .bus_val    (bus_val),
  .hs_req     (hs_req),
  .hs_ack     (hs_ack),
  .hs_rdy     (hs_rdy)
);

// File: tb/rdhs_top_tb_top.sv
`timescale 1ns/1ps
module rdhs_top_tb_top;
  localparam int unsigned W   = 32;
  localparam int unsigned LAT = 12;
  localparam int LIMIT        = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [W-1:0] cmd_addr = '0;
  logic         cmd_ready, done;
  logic [W-1:0] done_data, mem_addr, mem_rdata, bus_val;
  logic         bus_req_drv, bus_rsp_drv, hs_req, hs_ack, hs_rdy;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int overlap = 0;

  always #2 clk = ~clk;

  function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
    return ~{a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  rdhs_top #(.W(W), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .done(done), .done_data(done_data),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .bus_req_drv(bus_req_drv),
    .bus_rsp_drv(bus_rsp_drv), .bus_val(bus_val), .hs_req(hs_req),
    .hs_ack(hs_ack), .hs_rdy(hs_rdy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && bus_req_drv && bus_rsp_drv) overlap++;

  always @(posedge clk) if (cyc > LIMIT) begin
    n_run++; n_fail++;
    $display("FAIL watchdog: act cycle %0d exp below %0d", cyc, LIMIT);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [W-1:0] a, input bit stray);
    int t_ack = -1, t_rdy = -1, ndone = 0, rdy_while_busy = 0;
    bit pack = 0, prdy = 0, preq = 0, data_ph = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a;
    @(negedge clk);
    cmd_valid = stray; cmd_addr = stray ? ~a : a;
    pack = hs_ack; prdy = hs_rdy; preq = hs_req;
    for (int k = 0; k < 200 && ndone == 0; k++) begin
      if (cmd_ready) rdy_while_busy++;
      if (hs_ack && !pack && !hs_rdy) begin
        t_ack = cyc;
        chk(hs_req && mem_addr == a, "R4 addr captured at ack", mem_addr, a);
      end
      if (preq && !hs_req)
        chk(hs_ack && !bus_req_drv, "R5 req release under ack", {31'd0, hs_ack}, 1);
      if (hs_rdy && !prdy) begin
        t_rdy = cyc; data_ph = 1;
        chk(bus_rsp_drv && bus_val == mem_word(a), "R7 word on bus at rdy", bus_val, mem_word(a));
      end
      if (hs_ack && !pack && hs_rdy)
        chk(!bus_req_drv, "R8 data ack without drive", {31'd0, bus_req_drv}, 0);
      if (prdy && !hs_rdy)
        chk(hs_ack && !bus_rsp_drv, "R9 rdy drop under ack", {31'd0, hs_ack}, 1);
      if (done) begin
        ndone++;
        chk(done_data == mem_word(a), "R8 done data", done_data, mem_word(a));
        chk(data_ph && !hs_ack && !hs_rdy, "R10 ack low with done", {31'd0, hs_ack}, 0);
      end
      pack = hs_ack; prdy = hs_rdy; preq = hs_req;
      if (ndone == 0) @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(ndone == 1, "R8 one done per read", ndone, 1);
    chk(rdy_while_busy == 0, "R2 cmd_ready low while busy", rdy_while_busy, 0);
    // R6: exact gap when latency exceeds the release time
    chk(t_ack >= 0 && t_rdy - t_ack == int'(LAT) + 1, "R6 ack-to-rdy gap",
        t_rdy - t_ack, LAT + 1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready && !done, "R1 ready/done after reset", {31'd0, cmd_ready}, 1);
    chk(!hs_req && !hs_ack && !hs_rdy, "R1 lines low", {29'd0, hs_req, hs_ack, hs_rdy}, 0);
    chk(!bus_req_drv && !bus_rsp_drv, "R1 bus undriven", {30'd0, bus_req_drv, bus_rsp_drv}, 0);
  endtask

  task automatic t_patterns();
    do_read(32'h0000_1234, 0);
    do_read(32'h0000_0000, 0);
    do_read(32'hFFFF_FFFF, 0);
    do_read(32'hA5A5_5A5A, 0);
  endtask

  task automatic t_stray();
    int reqs = 0, dones = 0;
    do_read(32'h8000_0001, 1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (hs_req) reqs++;
      if (done) dones++;
    end
    chk(reqs == 0 && dones == 0, "R2 stray valid ignored", reqs + dones, 0);
    chk(mem_addr == 32'h8000_0001, "R2 no stray capture", mem_addr, 32'h8000_0001);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 3; i++) do_read(32'h1111_0000 + 32'(i * 4), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_stray();
    t_back_to_back();
    chk(overlap == 0, "R3 no dual drive", overlap, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule